// File: doc/BRIEF.md
# Quarter-Bit Two-Wire Sequencer

A small programmable sequencer that steps a two-wire open-drain bus (a clock line and a data line) in quarter-bit time slices. It knows nothing about any bus protocol. A host places 16-bit fixed-width instructions in a program memory and pulses `start`. The engine first writes a revision word to a result ring. It then fetches from address 0 and runs until a halt. Each multi-quarter instruction paces its quarters with the currently selected one of four divider slots. While it runs, the engine compares the synchronized bus against the values the program expects.

Four sticky flags record what happened: mismatch, timeout, bus start and bus stop. They are cleared only by the next start. The program may branch on them. Two 8-bit loop counters allow a loop inside a loop. Results go to a ring memory as tagged 16-bit records. The last slot of the ring is held back so that the halt record always has room.

The opcode field `instr[15:11]` has 32 slots and 15 of them are defined. Opcodes 12 to 14 belong to the target role and are not built. They trap, as does every reserved slot.

Top module: `qbit_engine`

## Requirements
- R1: On `start` while idle, the engine writes the revision word (parameter, default 16'h0A01) to ring address 0. It then fetches from program address 0, and the first record goes to address 1.
- R2: Opcode 1 (emit bit, `instr[0]` = data) lasts four quarters. The clock level is low, high, high, low across them and the data level equals `instr[0]` throughout. With the default divider value 1, the clock high pulse is 4 cycles long.
- R3: When `instr[1]` is set, emit bit compares the synchronized data line with `instr[2]` at the end of the third quarter and sets flag bit 0 (mismatch) if they differ. Opcode 2 (one quarter: `instr[0]` clock level, `instr[1]` data level) checks `instr[3]` in the same way when `instr[2]` is set.
- R4: Opcode 7 sets the bus mode from `instr[0]`. In mode 0 (open-drain) a high level releases the line and the `*_high_o` outputs never assert. In mode 1 (push-pull) a high level asserts `*_high_o`. The mode is 0 after each start, and no line is driven while idle.
- R5: Opcode 8 writes `instr[7:0]` into divider slot `instr[9:8]` when `instr[10]` is 0, and selects that slot for pacing when `instr[10]` is 1. A quarter lasts the slot value plus 1 cycles. Slot 0 is selected after each start.
- R6: Opcode 4 waits for a condition on the synchronized bus, chosen by `instr[1:0]`: 0 clock high, 1 clock low, 2 data high, 3 data low. It continues once the condition holds at a quarter end. After `WAIT_MAX` (default 64) quarters without the condition, it sets flag bit 1 (timeout) and falls through.
- R7: Opcode 5 jumps to `instr[7:0]`. Opcode 6 jumps to `instr[7:0]` only when flag `instr[9:8]` is set.
- R8: Opcode 10 loads counter `instr[8]` with `instr[7:0]`. Opcode 11 decrements counter `instr[8]` and jumps to `instr[7:0]` unless the old value was 1. A loop body loaded with N therefore runs N times, and two counters nest.
- R9: The bus lines pass through a two-stage synchronizer. A data fall while the clock stays high sets flag bit 2 (start), and a data rise while the clock stays high sets flag bit 3 (stop).
- R10: Opcode 9 writes record {4'h1, 1'b0, `instr[10:0]`} at the ring pointer while the pointer is below the last address. Once the pointer reaches the last address, further marks are dropped, and the halt record takes the last slot.
- R11: Opcode 0 writes the halt record {4'hE, 4'h0, flags[3:0], `instr[3:0]`} at the ring pointer, after which `done` is high for exactly one cycle. Flags stay set for the rest of the run and are cleared by the next start.
- R12: Opcodes 12 to 31 halt with status 4'hF.
- R13: Opcode 3 holds the clock low for `instr[7:0]`+1 quarters with the data line released, then releases the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run (ignored while busy) |
| busy | output | 1 | High from start until the run ends |
| done | output | 1 | One-cycle pulse after the halt record |
| prog_addr | output | PC_W | Program memory address |
| prog_data | input | 16 | Instruction at `prog_addr` (same-cycle read) |
| ring_we | output | 1 | Ring memory write strobe |
| ring_addr | output | RING_AW | Ring memory write address |
| ring_wdata | output | 16 | Ring memory write data |
| scl_i | input | 1 | Observed clock line |
| sda_i | input | 1 | Observed data line |
| scl_low_o | output | 1 | Pull the clock line low |
| scl_high_o | output | 1 | Push the clock line high (push-pull mode only) |
| sda_low_o | output | 1 | Pull the data line low |
| sda_high_o | output | 1 | Push the data line high (push-pull mode only) |

## Verification
The flag register takes updates from two sources: the bus observer's start/stop detection and the instruction datapath's mismatch or timeout result. Both can arrive in the same cycle. A run that emits a start and a stop by single quarters, as well as runs that create a mismatch or a timeout, make both sources write the flags. The result is judged from the flag field of the halt record, which must hold the union of every event. The second overlap is at the ring limit. A looped mark program fills the ring so that the last accepted mark and the halt record meet at the reserved slot. The bench checks the halt address, the last mark and the total write count.

// File: rtl/qbe_pkg.sv
package qbe_pkg;
    localparam logic [4:0] OP_HALT     = 5'd0;
    localparam logic [4:0] OP_EMIT_BIT = 5'd1;
    localparam logic [4:0] OP_EMIT_QTR = 5'd2;
    localparam logic [4:0] OP_STRETCH  = 5'd3;
    localparam logic [4:0] OP_WAIT     = 5'd4;
    localparam logic [4:0] OP_JMP      = 5'd5;
    localparam logic [4:0] OP_BRANCH   = 5'd6;
    localparam logic [4:0] OP_MODE     = 5'd7;
    localparam logic [4:0] OP_TIMING   = 5'd8;
    localparam logic [4:0] OP_MARK     = 5'd9;
    localparam logic [4:0] OP_LOOP     = 5'd10;
    localparam logic [4:0] OP_DECBR    = 5'd11;

    localparam int FL_MISMATCH = 0;
    localparam int FL_TIMEOUT  = 1;
    localparam int FL_START    = 2;
    localparam int FL_STOP     = 3;

    localparam logic [3:0] TAG_MARK    = 4'h1;
    localparam logic [3:0] TAG_HALT    = 4'hE;
    localparam logic [3:0] TRAP_STATUS = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REV, ST_EXEC, ST_RUN, ST_HALTW, ST_DONE
    } state_e;
endpackage

// File: rtl/qbe_observer.sv
module qbe_observer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic scl_p;
        logic sda_p;
    } obs_t;

    obs_t q, d;

    always_comb begin
        d = q;
        d.scl_sh = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[SYNC_STAGES-1];
        d.sda_p  = q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s    = q.scl_sh[SYNC_STAGES-1];
    assign sda_s    = q.sda_sh[SYNC_STAGES-1];
    assign start_ev = scl_s && q.scl_p && q.sda_p && !sda_s;
    assign stop_ev  = scl_s && q.scl_p && !q.sda_p && sda_s;

    // R9: an event may only be reported while the clock stays high
    p_event_clock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |-> $past(scl_s));
endmodule

// File: rtl/qbe_pacer.sv
module qbe_pacer #(
    parameter int DIV_W     = 8,
    parameter int SLOTS     = 4,
    parameter int DIV_RESET = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     sel_clr,
    input  logic                     wr_en,
    input  logic                     sel_en,
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [DIV_W-1:0]         val,
    output logic                     tick
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [DIV_W-1:0]  div_q [SLOTS];
    logic [SLOT_W-1:0] sel_q, sel_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              div_q[i] <= DIV_W'(DIV_RESET);
            else if (wr_en && slot == SLOT_W'(i))    div_q[i] <= val;
        end
    end

    always_comb begin
        tick  = run && (cnt_q == div_q[sel_q]);
        cnt_d = (run && !tick) ? cnt_q + 1'b1 : '0;
        sel_d = sel_q;
        if (sel_clr)     sel_d = '0;
        else if (sel_en) sel_d = slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            sel_q <= sel_d;
            cnt_q <= cnt_d;
        end
    end

    // R5: a quarter never runs past its selected divider value
    p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div_q[sel_q]));
endmodule

// File: rtl/qbe_line_drv.sv
module qbe_line_drv (
    input  logic en,
    input  logic pp,
    input  logic lvl,
    output logic low,
    output logic high
);
    assign low  = en & ~lvl;
    assign high = en & pp & lvl;
endmodule

// File: rtl/qbit_engine.sv
module qbit_engine
    import qbe_pkg::*;
#(
    parameter int          PC_W      = 8,
    parameter int          RING_AW   = 4,
    parameter int          DIV_W     = 8,
    parameter int          WAIT_MAX  = 64,
    parameter int          DIV_RESET = 1,
    parameter logic [15:0] REVISION  = 16'h0A01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [PC_W-1:0]    prog_addr,
    input  logic [15:0]        prog_data,
    output logic               ring_we,
    output logic [RING_AW-1:0] ring_addr,
    output logic [15:0]        ring_wdata,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               scl_low_o,
    output logic               scl_high_o,
    output logic               sda_low_o,
    output logic               sda_high_o
);
    localparam int WAIT_W = $clog2(WAIT_MAX + 1);
    localparam int CNT_W  = (WAIT_W > 9) ? WAIT_W : 9;
    localparam logic [RING_AW-1:0] LIMIT = {RING_AW{1'b1}};

    typedef struct packed {
        state_e          st;
        logic [PC_W-1:0] pc;
        logic [15:0]     op;
        logic [1:0]      qidx;
        logic [CNT_W-1:0] qcnt;
        logic            scl_lvl;
        logic            sda_lvl;
        logic            pp;
        logic [1:0][7:0] lcnt;
        logic [3:0]      flags;
        logic [RING_AW-1:0] ptr;
        logic [3:0]      status;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s, start_ev, stop_ev, tick;
    logic tm_wr, tm_sel, sel_clr;
    logic drv_scl, drv_sda, met;
    logic [4:0] opc, opr;
    logic [1:0] lvl_v, low_v, high_v;

    qbe_observer #(.SYNC_STAGES(2)) u_obs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    qbe_pacer #(.DIV_W(DIV_W), .SLOTS(4), .DIV_RESET(DIV_RESET)) u_pace (
        .clk(clk), .rst_n(rst_n), .run(q.st == ST_RUN), .sel_clr(sel_clr),
        .wr_en(tm_wr), .sel_en(tm_sel), .slot(prog_data[9:8]),
        .val(DIV_W'(prog_data[7:0])), .tick(tick)
    );

    assign opc = prog_data[15:11];
    assign opr = q.op[15:11];

    always_comb begin
        d          = q;
        ring_we    = 1'b0;
        ring_addr  = q.ptr;
        ring_wdata = '0;
        tm_wr      = 1'b0;
        tm_sel     = 1'b0;
        sel_clr    = 1'b0;
        drv_scl    = q.scl_lvl;
        drv_sda    = q.sda_lvl;
        met        = 1'b0;

        if (q.st != ST_IDLE) begin
            if (start_ev) d.flags[FL_START] = 1'b1;
            if (stop_ev)  d.flags[FL_STOP]  = 1'b1;
        end

        case (q.st)
            ST_IDLE: if (start) begin
                d.st      = ST_REV;
                d.pc      = '0;
                d.ptr     = RING_AW'(1);
                d.flags   = '0;
                d.pp      = 1'b0;
                d.scl_lvl = 1'b1;
                d.sda_lvl = 1'b1;
                sel_clr   = 1'b1;
            end
            ST_REV: begin
                ring_we    = 1'b1;
                ring_addr  = '0;
                ring_wdata = REVISION;
                d.st       = ST_EXEC;
            end
            ST_EXEC: begin
                d.pc   = q.pc + 1'b1;
                d.op   = prog_data;
                d.qidx = '0;
                d.qcnt = '0;
                case (opc)
                    OP_HALT: begin
                        d.status = prog_data[3:0];
                        d.st     = ST_HALTW;
                    end
                    OP_EMIT_BIT, OP_EMIT_QTR, OP_STRETCH, OP_WAIT: d.st = ST_RUN;
                    OP_JMP:    d.pc = prog_data[PC_W-1:0];
                    OP_BRANCH: if (q.flags[prog_data[9:8]]) d.pc = prog_data[PC_W-1:0];
                    OP_MODE:   d.pp = prog_data[0];
                    OP_TIMING: begin
                        tm_sel = prog_data[10];
                        tm_wr  = !prog_data[10];
                    end
                    OP_MARK: if (q.ptr != LIMIT) begin
                        ring_we    = 1'b1;
                        ring_wdata = {TAG_MARK, 1'b0, prog_data[10:0]};
                        d.ptr      = q.ptr + 1'b1;
                    end
                    OP_LOOP:  d.lcnt[prog_data[8]] = prog_data[7:0];
                    OP_DECBR: begin
                        d.lcnt[prog_data[8]] = q.lcnt[prog_data[8]] - 8'd1;
                        if (q.lcnt[prog_data[8]] != 8'd1) d.pc = prog_data[PC_W-1:0];
                    end
                    default: begin
                        d.status = TRAP_STATUS;
                        d.st     = ST_HALTW;
                    end
                endcase
            end
            ST_RUN: begin
                case (opr)
                    OP_EMIT_BIT: begin
                        drv_scl = q.qidx[0] ^ q.qidx[1];
                        drv_sda = q.op[0];
                        if (tick) begin
                            if (q.qidx == 2'd2 && q.op[1] && (sda_s != q.op[2]))
                                d.flags[FL_MISMATCH] = 1'b1;
                            if (q.qidx == 2'd3) begin
                                d.st      = ST_EXEC;
                                d.scl_lvl = 1'b0;
                                d.sda_lvl = q.op[0];
                            end else begin
                                d.qidx = q.qidx + 1'b1;
                            end
                        end
                    end
                    OP_EMIT_QTR: begin
                        drv_scl = q.op[0];
                        drv_sda = q.op[1];
                        if (tick) begin
                            if (q.op[2] && (sda_s != q.op[3]))
                                d.flags[FL_MISMATCH] = 1'b1;
                            d.st      = ST_EXEC;
                            d.scl_lvl = q.op[0];
                            d.sda_lvl = q.op[1];
                        end
                    end
                    OP_STRETCH: begin
                        drv_scl = 1'b0;
                        drv_sda = 1'b1;
                        if (tick) begin
                            if (q.qcnt == CNT_W'(q.op[7:0])) begin
                                d.st      = ST_EXEC;
                                d.scl_lvl = 1'b1;
                                d.sda_lvl = 1'b1;
                            end else begin
                                d.qcnt = q.qcnt + 1'b1;
                            end
                        end
                    end
                    OP_WAIT: begin
                        case (q.op[1:0])
                            2'd0: met = scl_s;
                            2'd1: met = !scl_s;
                            2'd2: met = sda_s;
                            default: met = !sda_s;
                        endcase
                        if (tick) begin
                            if (met) begin
                                d.st = ST_EXEC;
                            end else if (q.qcnt == CNT_W'(WAIT_MAX - 1)) begin
                                d.flags[FL_TIMEOUT] = 1'b1;
                                d.st = ST_EXEC;
                            end else begin
                                d.qcnt = q.qcnt + 1'b1;
                            end
                        end
                    end
                    default: d.st = ST_EXEC;
                endcase
            end
            ST_HALTW: begin
                ring_we    = 1'b1;
                ring_wdata = {TAG_HALT, 4'h0, q.flags, q.status};
                d.st       = ST_DONE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.scl_lvl <= 1'b1;
            q.sda_lvl <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign prog_addr = q.pc;
    assign lvl_v     = {drv_sda, drv_scl};

    for (genvar i = 0; i < 2; i++) begin : g_line
        qbe_line_drv u_drv (
            .en(busy), .pp(q.pp), .lvl(lvl_v[i]), .low(low_v[i]), .high(high_v[i])
        );
    end

    assign scl_low_o  = low_v[0];
    assign sda_low_o  = low_v[1];
    assign scl_high_o = high_v[0];
    assign sda_high_o = high_v[1];

    // R11: done only follows the halt record write
    p_done_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ring_we));
    // R11: flags never clear during a run
    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> ((q.flags & $past(q.flags)) == $past(q.flags)));
    // R4: open-drain mode never pushes a line high
    p_od_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pp |-> !(scl_high_o || sda_high_o));
    // R10: only the halt record may occupy the reserved last slot
    p_halt_slot_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_we && ring_addr == LIMIT) |-> (ring_wdata[15:12] == TAG_HALT));
    // R12: undefined and target-role opcodes halt with the trap status
    p_trap_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && opc >= 5'd12) |=> (ring_we && ring_wdata[3:0] == TRAP_STATUS));
endmodule

// File: tb/qbit_engine_test.sv
module qbit_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic clr = 1'b0;
    logic busy, done, ring_we;
    logic [7:0]  prog_addr;
    logic [15:0] prog_data, ring_wdata;
    logic [3:0]  ring_addr;
    logic scl_low_o, scl_high_o, sda_low_o, sda_high_o;
    logic scl_bus, sda_bus;

    logic [15:0] prog [256];
    logic [15:0] ring_mem [16];

    int checks = 0;
    int failures = 0;
    int wr_cnt, done_cnt, hi_cnt, sda_lo_cnt, hi_len, lo_len, last_hi, last_lo;
    logic [3:0]  last_addr;
    logic [15:0] last_data;
    logic scl_prev;

    always #5 clk = ~clk;

    assign scl_bus   = ~scl_low_o;
    assign sda_bus   = ~sda_low_o;
    assign prog_data = prog[prog_addr];

    qbit_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .ring_we(ring_we), .ring_addr(ring_addr), .ring_wdata(ring_wdata),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_low_o(scl_low_o), .scl_high_o(scl_high_o),
        .sda_low_o(sda_low_o), .sda_high_o(sda_high_o)
    );

    // observation at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (clr) begin
            wr_cnt = 0; done_cnt = 0; hi_cnt = 0; sda_lo_cnt = 0;
            last_hi = 0; last_lo = 0; hi_len = 0; lo_len = 0;
            last_addr = '0; last_data = '0;
        end else begin
            if (ring_we) begin
                ring_mem[ring_addr] = ring_wdata;
                wr_cnt++;
                last_addr = ring_addr;
                last_data = ring_wdata;
            end
            if (done) done_cnt++;
            if (scl_high_o || sda_high_o) hi_cnt++;
            if (sda_low_o) sda_lo_cnt++;
            if (scl_bus) begin
                if (!scl_prev) begin last_lo = lo_len; hi_len = 1; end
                else hi_len++;
            end else begin
                if (scl_prev) begin last_hi = hi_len; lo_len = 1; end
                else lo_len++;
            end
        end
        scl_prev = scl_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    endtask

    task automatic run_prog();
        int n;
        @(posedge clk); #2 clr = 1'b1;
        @(posedge clk); #2 clr = 1'b0; start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) begin
            failures++;
            $display("FAIL watchdog run did not finish actual=%0d expected=<5000", n);
        end
        repeat (6) @(negedge clk);
    endtask

    // {instr0, instr1, instr2, expected halt record}; instr3 is HALT status 5
    localparam logic [63:0] VEC [10] = '{
        {16'h0807, 16'h3800, 16'h2803, 16'hE005},  // R2/R7 bit 1 as expected, jump to halt
        {16'h0803, 16'h3800, 16'h3800, 16'hE015},  // R3 released line read 1, expected 0
        {16'h0802, 16'h3800, 16'h3800, 16'hE005},  // R3 driven 0 as expected
        {16'h2000, 16'h3800, 16'h3800, 16'hE005},  // R6 clock high met at once
        {16'h2001, 16'h3800, 16'h3800, 16'hE025},  // R6 clock low never met: timeout
        {16'h0803, 16'h3003, 16'h0001, 16'hE015},  // R7 branch on mismatch taken
        {16'h6000, 16'h3800, 16'h3800, 16'hE00F},  // R12 target-role opcode traps
        {16'hF800, 16'h3800, 16'h3800, 16'hE00F},  // R12 last reserved slot traps
        {16'h1001, 16'h1003, 16'h3800, 16'hE0C5},  // R9 start then stop
        {16'h0009, 16'h3800, 16'h3800, 16'hE009}   // R11 immediate halt status 9
    };

    initial begin
        clear_prog();
        repeat (3) @(negedge clk);
        // R1 reset state of the ports
        chk(!busy && !done && !ring_we, "R1 reset idle", {busy, done, ring_we}, 0);
        chk(!(scl_low_o | scl_high_o | sda_low_o | sda_high_o), "R4 reset no drive",
            {scl_low_o, scl_high_o, sda_low_o, sda_high_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            clear_prog();
            prog[0] = VEC[v][63:48];
            prog[1] = VEC[v][47:32];
            prog[2] = VEC[v][31:16];
            prog[3] = 16'h0005;
            run_prog();
            chk(last_data == VEC[v][15:0], $sformatf("R11 vector %0d halt record", v),
                last_data, VEC[v][15:0]);
            chk(last_addr == 4'd1, $sformatf("R1 vector %0d halt address", v), last_addr, 1);
            chk(done_cnt == 1, $sformatf("R11 vector %0d single done", v), done_cnt, 1);
            chk(hi_cnt == 0, $sformatf("R4 vector %0d open-drain push", v), hi_cnt, 0);
            if (v == 0) begin
                chk(ring_mem[0] == 16'h0A01, "R1 revision word", ring_mem[0], 16'h0A01);
                chk(last_hi == 4, "R2 clock high width", last_hi, 4);
            end
        end

        // R4 push-pull drives high
        clear_prog();
        prog[0] = 16'h3801; prog[1] = 16'h0807; prog[2] = 16'h0000;
        run_prog();
        chk(hi_cnt > 0, "R4 push-pull drives high", hi_cnt, 1);
        chk(last_data == 16'hE000, "R4 push-pull halt record", last_data, 16'hE000);

        // R13 stretch of 3 quarters, data released
        clear_prog();
        prog[0] = 16'h1802; prog[1] = 16'h0000;
        run_prog();
        chk(last_lo == 6, "R13 stretch low width", last_lo, 6);
        chk(sda_lo_cnt == 0, "R13 data released", sda_lo_cnt, 0);

        // R8 single loop of 3
        clear_prog();
        prog[0] = 16'h5003; prog[1] = 16'h4801; prog[2] = 16'h5801; prog[3] = 16'h0005;
        run_prog();
        chk(wr_cnt == 5, "R8 loop writes", wr_cnt, 5);
        chk(last_addr == 4'd4, "R8 loop halt address", last_addr, 4);
        chk(ring_mem[1] == 16'h1001, "R10 mark record", ring_mem[1], 16'h1001);

        // R8 nested loops 2 x 2
        clear_prog();
        prog[0] = 16'h5102; prog[1] = 16'h5002; prog[2] = 16'h4801;
        prog[3] = 16'h5802; prog[4] = 16'h5901; prog[5] = 16'h0005;
        run_prog();
        chk(wr_cnt == 6, "R8 nested loop writes", wr_cnt, 6);

        // R10 overflow: 20 marks into 14 free slots
        clear_prog();
        prog[0] = 16'h5014; prog[1] = 16'h4801; prog[2] = 16'h5801; prog[3] = 16'h0005;
        run_prog();
        chk(last_addr == 4'd15, "R10 halt in reserved slot", last_addr, 15);
        chk(last_data == 16'hE005, "R10 halt record after overflow", last_data, 16'hE005);
        chk(ring_mem[14] == 16'h1001, "R10 last mark slot", ring_mem[14], 16'h1001);
        chk(wr_cnt == 16, "R10 dropped marks", wr_cnt, 16);

        // R5 divider slot 1 = 4 selected: high pulse 2 x 5 cycles
        clear_prog();
        prog[0] = 16'h4104; prog[1] = 16'h4500; prog[2] = 16'h0807; prog[3] = 16'h0000;
        run_prog();
        chk(last_hi == 10, "R5 selected slot pacing", last_hi, 10);

        // R5 slot 0 reselected after start
        clear_prog();
        prog[0] = 16'h0807; prog[1] = 16'h0000;
        run_prog();
        chk(last_hi == 4, "R5 slot 0 after start", last_hi, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog global timeout actual=150000 expected=less");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule